// File: doc/BRIEF.md
# Compare/Capture Timer

A 16-bit up-counter with one timing channel, reached through a byte-wide register port (write strobe, address, write data, combinational read data). The counter advances once per tick of a power-of-two prescaler, and it runs only while a run bit is set. It counts up to 0xFFFF, wraps to 0x0000 and keeps going.

The single channel register serves two uses, chosen by a mode bit. In compare mode, software loads a target value, and a sticky event flag rises on the clock edge at which the counter reaches that value. In capture mode, a synchronised external pin is watched for a chosen edge kind, and on such an edge the current count is copied into the channel register and the same flag is raised. Software clears the flag by writing a one to its bit. An interrupt line mirrors the flag while the interrupt enable is set.

Typical use is a polled delay: read the count, add a delay, write the sum into the channel, clear the flag, then wait for the flag. A second use is to time edges on the pin by reading successive captured values.

Top module: `cc_timer`

## Requirements
- R1: The counter advances only while bit 7 of the run register (address 0x0) is 1; while that bit is 0, the count holds its value.
- R2: The count is 16 bits wide and steps up by one per advance, wrapping from 0xFFFF to 0x0000.
- R3: Bits [2:0] of the prescale register (address 0x1) hold a code k from 0 to 7, and the counter advances once every 2^k clocks. The first advance falls 2^k clocks after the edge that sets the run bit.
- R4: Bit 0 of the mode register (address 0x2) selects compare (1) or capture (0). Bits [2:1] select the capture edge: 00 none, 01 rising, 10 falling, 11 both. Pin edges have no effect in compare mode.
- R5: In compare mode, the flag (bit 0 at address 0x4) becomes 1 on the clock edge at which the count steps to the channel value. It then stays 1 until software clears it.
- R6: Writing a 1 to bit 0 at address 0x4 clears the flag. Writing a 0 there leaves the flag unchanged. A flag-setting event in the same cycle wins over the clear.
- R7: In capture mode, a selected pin edge loads the count into the channel register and sets the flag. The pin passes through a two-flop synchroniser, so the load occurs on the third rising clock edge after the pin changes.
- R8: The irq output is 1 exactly when the flag and bit 0 of the interrupt-enable register (address 0x3) are both 1. Reset clears every register, the count, the channel and the flag.
- R9: The count reads as a high byte at 0x5 and a low byte at 0x6. The channel reads and writes as a high byte at 0x7 and a low byte at 0x8. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| we | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| cap_pin | input | 1 | Asynchronous capture input |
| irq | output | 1 | Flag gated by the interrupt enable |

## Verification
The embedded properties check on every cycle that the count holds while stopped and steps by exactly one (wrapping) when it advances. They also check that the flag stays set unless a write of one clears it, that a compare hit leaves the count equal to the channel with the flag set, and that a capture loads the previous count along with the flag. The prescale spacing for each code, the exact cycle of the first advance, the three-edge capture latency, the per-mode edge filtering, and the register byte layout depend on the sequence of stimulus. Only the directed scenarios can show those.

// File: rtl/cc_timer_pkg.sv
// Package: register addresses and shared encodings of the compare/capture timer.
// Assumes a 4-bit byte-wide register address space.
package cc_timer_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_RUN   = 4'h0;
    localparam logic [ADDR_W-1:0] A_PSC   = 4'h1;
    localparam logic [ADDR_W-1:0] A_MODE  = 4'h2;
    localparam logic [ADDR_W-1:0] A_IEN   = 4'h3;
    localparam logic [ADDR_W-1:0] A_FLAG  = 4'h4;
    localparam logic [ADDR_W-1:0] A_CNTH  = 4'h5;
    localparam logic [ADDR_W-1:0] A_CNTL  = 4'h6;
    localparam logic [ADDR_W-1:0] A_CHH   = 4'h7;
    localparam logic [ADDR_W-1:0] A_CHL   = 4'h8;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_t;
endpackage

// File: rtl/cc_prescaler.sv
// Module: power-of-two tick generator for the timer counter.
// Emits one tick every 2^ps_sel clocks while run is high; the divider
// restarts from zero whenever run is low, so the first tick lands
// 2^ps_sel clocks after run rises.
module cc_prescaler #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PS_W-1:0] ps_sel,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    // Low ps_sel bits of the divider must all be ones for a tick.
    always_comb begin
        mask = ~({DIV_W{1'b1}} << ps_sel);
        tick = run && ((div_q & mask) == mask);
    end

    // Free-running divider, held at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/cc_edge_sync.sv
// Module: two-flop synchroniser plus edge filter for the capture pin.
// Assumes the pin is low while reset is held; an event is flagged one
// cycle after the synchronised level changes, per the edge selection.
module cc_edge_sync
    import cc_timer_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_i,
    input  edge_sel_t sel,
    output logic      evt
);
    logic s1_q, s2_q, s3_q;

    // Synchronise the pin and keep one older sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= pin_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    // Qualify rising and falling transitions with the selection bits.
    always_comb begin
        evt = (sel[0] && s2_q && !s3_q) || (sel[1] && !s2_q && s3_q);
    end
endmodule

// File: rtl/cc_timer.sv
// Module: 16-bit timer with one channel shared by compare and capture.
// Holds the register file, counter, channel and sticky flag; relies on
// cc_prescaler for the count rate and cc_edge_sync for pin events.
// Assumes CNT_W is twice DATA_W so each value splits into two bytes.
module cc_timer
    import cc_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8,
    parameter int PS_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              cap_pin,
    output logic              irq
);
    localparam int HI_LSB = CNT_W - DATA_W;

    logic             run_q;
    logic [PS_W-1:0]  ps_q;
    logic             cmp_mode_q;
    edge_sel_t        edge_sel_q;
    logic             ien_q;
    logic             flag_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ch_q;

    logic             tick;
    logic             pin_evt;
    logic             advance;
    logic             cmp_hit;
    logic             cap_hit;
    logic             flag_clr;
    logic [CNT_W-1:0] cnt_next;

    cc_prescaler #(.PS_W(PS_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_q),
        .ps_sel (ps_q),
        .tick   (tick)
    );

    cc_edge_sync u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (cap_pin),
        .sel   (edge_sel_q),
        .evt   (pin_evt)
    );

    // Decode counter steps and the two flag-setting events.
    always_comb begin
        advance  = run_q && tick;
        cnt_next = cnt_q + 1'b1;
        cmp_hit  = cmp_mode_q && advance && (cnt_next == ch_q);
        cap_hit  = !cmp_mode_q && pin_evt;
        flag_clr = we && (addr == A_FLAG) && wdata[0];
    end

    // Control registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q      <= 1'b0;
            ps_q       <= '0;
            cmp_mode_q <= 1'b0;
            edge_sel_q <= EDGE_NONE;
            ien_q      <= 1'b0;
        end else if (we) begin
            case (addr)
                A_RUN:  run_q <= wdata[DATA_W-1];
                A_PSC:  ps_q  <= wdata[PS_W-1:0];
                A_MODE: begin
                    cmp_mode_q <= wdata[0];
                    edge_sel_q <= edge_sel_t'(wdata[2:1]);
                end
                A_IEN:  ien_q <= wdata[0];
                default: ;
            endcase
        end
    end

    // Free-running counter, wrapping naturally at its width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (advance) begin
            cnt_q <= cnt_next;
        end
    end

    // Channel register: capture has priority over software byte writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q <= '0;
        end else if (cap_hit) begin
            ch_q <= cnt_q;
        end else if (we && addr == A_CHH) begin
            ch_q[CNT_W-1:HI_LSB] <= wdata;
        end else if (we && addr == A_CHL) begin
            ch_q[DATA_W-1:0] <= wdata;
        end
    end

    // Sticky flag: events set it, a written one clears it, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (cmp_hit || cap_hit) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    // Interrupt request follows the enabled flag.
    always_comb begin
        irq = flag_q && ien_q;
    end

    // Combinational read mux; unmapped addresses read zero.
    always_comb begin
        rdata = '0;
        case (addr)
            A_RUN:  rdata[DATA_W-1] = run_q;
            A_PSC:  rdata[PS_W-1:0] = ps_q;
            A_MODE: rdata[2:0] = {edge_sel_q, cmp_mode_q};
            A_IEN:  rdata[0] = ien_q;
            A_FLAG: rdata[0] = flag_q;
            A_CNTH: rdata = cnt_q[CNT_W-1:HI_LSB];
            A_CNTL: rdata = cnt_q[DATA_W-1:0];
            A_CHH:  rdata = ch_q[CNT_W-1:HI_LSB];
            A_CHL:  rdata = ch_q[DATA_W-1:0];
            default: rdata = '0;
        endcase
    end

    // R1: a stopped counter keeps its value.
    a_r1_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> $stable(cnt_q));

    // R2: each advance steps the count by exactly one, wrapping.
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && tick) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    // R5: a compare hit leaves count equal to channel with the flag set.
    a_r5_match_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_hit |=> (flag_q && cnt_q == ch_q));

    // R6: the flag survives every cycle without a written one.
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);

    // R7: a capture loads the prior count and raises the flag.
    a_r7_capture_load: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hit |=> (flag_q && ch_q == $past(cnt_q)));
endmodule

// File: tb/cc_timer_bench.sv
// Directed bench for cc_timer: one task per scenario, each checking itself.
module cc_timer_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       cap_pin = 1'b0;
    logic       irq;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;

    cc_timer u_cc_timer (
        .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cap_pin(cap_pin), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a miscompare and still summarises.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 190000) begin
            miscompares = miscompares + 1;
            $display("FAIL watchdog: got %0d cycles exp fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        vectors = vectors + 1;
        if (got !== exp) begin
            miscompares = miscompares + 1;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; we = 1'b0; cap_pin = 1'b0;
        wait_cyc(2);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic rd_cnt(output logic [15:0] v);
        logic [7:0] h, l;
        rd(4'h5, h); rd(4'h6, l);
        v = {h, l};
    endtask

    task automatic rd_ch(output logic [15:0] v);
        logic [7:0] h, l;
        rd(4'h7, h); rd(4'h8, l);
        v = {h, l};
    endtask

    task automatic rd_flag(output logic f);
        logic [7:0] d;
        rd(4'h4, d);
        f = d[0];
    endtask

    // R8 R9: every register, the count and irq read zero after reset.
    task automatic test_reset();
        logic [7:0] d;
        do_reset();
        for (int a = 0; a < 16; a++) begin
            rd(a[3:0], d);
            check($sformatf("R8 reset value at addr %0d", a), {8'h0, d}, 16'h0);
        end
        check("R8 irq after reset", {15'h0, irq}, 16'h0);
    endtask

    // R3 R1: prescale codes 0 and 3 set the advance spacing; stop holds.
    task automatic test_prescale();
        logic [15:0] v;
        do_reset();
        wr(4'h1, 8'h03);
        wr(4'h0, 8'h80);
        wait_cyc(7);
        rd_cnt(v); check("R3 div8 before first tick", v, 16'd0);
        wait_cyc(1);
        rd_cnt(v); check("R3 div8 first tick at 8 clocks", v, 16'd1);
        wait_cyc(31);
        rd_cnt(v); check("R3 div8 after 39 clocks", v, 16'd4);
        wait_cyc(1);
        rd_cnt(v); check("R3 div8 after 40 clocks", v, 16'd5);
        wr(4'h0, 8'h00);
        rd_cnt(v);
        wait_cyc(50);
        begin
            logic [15:0] v2;
            rd_cnt(v2); check("R1 counter holds while stopped", v2, v);
        end
        do_reset();
        wr(4'h1, 8'h00);
        wr(4'h0, 8'h80);
        wait_cyc(13);
        rd_cnt(v); check("R3 div1 advances every clock", v, 16'd13);
        do_reset();
        wr(4'h1, 8'h07);
        wr(4'h0, 8'h80);
        wait_cyc(127);
        rd_cnt(v); check("R3 div128 before first tick", v, 16'd0);
        wait_cyc(1);
        rd_cnt(v); check("R3 div128 first tick", v, 16'd1);
    endtask

    // R2 R1: full-speed run reaches 0xFFFF then wraps to zero.
    task automatic test_wrap();
        logic [15:0] v;
        do_reset();
        wr(4'h0, 8'h80);
        wait_cyc(65535);
        rd_cnt(v); check("R2 count reaches FFFF", v, 16'hFFFF);
        wait_cyc(1);
        rd_cnt(v); check("R2 count wraps to 0000", v, 16'h0000);
        wait_cyc(1);
        rd_cnt(v); check("R2 count continues after wrap", v, 16'h0001);
    endtask

    // R5 R6 R8: compare hit timing, stickiness, write-one clear, irq gate.
    task automatic test_compare();
        logic [15:0] v;
        logic f;
        do_reset();
        wr(4'h7, 8'h00);
        wr(4'h8, 8'd20);
        wr(4'h2, 8'h01);
        wr(4'h0, 8'h80);
        wait_cyc(19);
        rd_flag(f); check("R5 flag low before match", {15'h0, f}, 16'h0);
        wait_cyc(1);
        rd_flag(f); check("R5 flag set at match", {15'h0, f}, 16'h1);
        rd_cnt(v); check("R5 count equals channel at flag", v, 16'd20);
        check("R8 irq low while disabled", {15'h0, irq}, 16'h0);
        wait_cyc(10);
        rd_flag(f); check("R5 flag stays set", {15'h0, f}, 16'h1);
        wr(4'h3, 8'h01);
        check("R8 irq high with enable", {15'h0, irq}, 16'h1);
        wr(4'h4, 8'h00);
        rd_flag(f); check("R6 writing zero keeps flag", {15'h0, f}, 16'h1);
        wr(4'h4, 8'h01);
        rd_flag(f); check("R6 writing one clears flag", {15'h0, f}, 16'h0);
        check("R8 irq drops with flag", {15'h0, irq}, 16'h0);
    endtask

    // R7 R4: capture latency, loaded value and edge-selection filtering.
    task automatic test_capture();
        logic [15:0] c, v;
        logic f;
        do_reset();
        wr(4'h0, 8'h80);
        wait_cyc(50);
        wr(4'h0, 8'h00);
        rd_cnt(c);
        wr(4'h2, 8'h02);
        @(negedge clk); cap_pin = 1'b1;
        wait_cyc(2);
        rd_flag(f); check("R7 no capture before third edge", {15'h0, f}, 16'h0);
        wait_cyc(1);
        rd_flag(f); check("R7 rising edge sets flag", {15'h0, f}, 16'h1);
        rd_ch(v); check("R7 channel holds captured count", v, c);
        wr(4'h4, 8'h01);
        @(negedge clk); cap_pin = 1'b0;
        wait_cyc(6);
        rd_flag(f); check("R4 falling edge ignored in rising mode", {15'h0, f}, 16'h0);
        wr(4'h2, 8'h04);
        @(negedge clk); cap_pin = 1'b1;
        wait_cyc(6);
        rd_flag(f); check("R4 rising edge ignored in falling mode", {15'h0, f}, 16'h0);
        @(negedge clk); cap_pin = 1'b0;
        wait_cyc(6);
        rd_flag(f); check("R4 falling mode captures fall", {15'h0, f}, 16'h1);
        wr(4'h4, 8'h01);
        wr(4'h2, 8'h00);
        @(negedge clk); cap_pin = 1'b1;
        wait_cyc(6);
        rd_flag(f); check("R4 selection none ignores edges", {15'h0, f}, 16'h0);
        wr(4'h2, 8'h06);
        @(negedge clk); cap_pin = 1'b0;
        wait_cyc(6);
        rd_flag(f); check("R4 both mode captures fall", {15'h0, f}, 16'h1);
        wr(4'h4, 8'h01);
        @(negedge clk); cap_pin = 1'b1;
        wait_cyc(6);
        rd_flag(f); check("R4 both mode captures rise", {15'h0, f}, 16'h1);
        wr(4'h4, 8'h01);
        wr(4'h7, 8'hA5);
        wr(4'h8, 8'h3C);
        wr(4'h2, 8'h07);
        @(negedge clk); cap_pin = 1'b0;
        wait_cyc(6);
        rd_flag(f); check("R4 compare mode ignores pin", {15'h0, f}, 16'h0);
        rd_ch(v); check("R4 channel untouched in compare mode", v, 16'hA53C);
    endtask

    // R9: channel bytes at their addresses, unmapped reads zero.
    task automatic test_regs();
        logic [15:0] v;
        logic [7:0] d;
        do_reset();
        wr(4'h7, 8'h12);
        wr(4'h8, 8'h34);
        rd_ch(v); check("R9 channel byte layout", v, 16'h1234);
        wr(4'hB, 8'hFF);
        rd(4'hB, d); check("R9 unmapped address reads zero", {8'h0, d}, 16'h0);
        wr(4'h1, 8'h05);
        rd(4'h1, d); check("R9 prescale readback", {8'h0, d}, 16'h0005);
    endtask

    initial begin
        test_reset();
        test_prescale();
        test_wrap();
        test_compare();
        test_capture();
        test_regs();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule